// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of an integrating dual-slope analog-to-digital converter. The external analog parts are an integrator, a reference and a zero-crossing comparator. A start request begins a conversion in two phases. In the first phase the block steers the unknown input onto the integrator for a fixed number of clock cycles. In the second phase it steers the negative reference onto the integrator, counts again from zero, and stops when the comparator shows that the integrator has returned to zero.

The charge built up in the first phase is proportional to the input, and the reference removes it at a constant rate. The second count is therefore proportional to the input voltage, and it becomes the conversion result. While the block is idle, an auto-zero select holds the integrator in reset. The comparator is asynchronous to the clock and passes through a two-flop synchronizer before the block uses it. A discharge that never ends is cut off at the full count of the counter. In that case the result saturates and an overrange flag is raised.

Top module: `dual_slope_ctrl`

## Requirements
- R1: After a start is accepted, `selInput` is high for exactly `INT_TICKS` consecutive cycles (phase one), beginning on the first clock edge after the start is sampled.
- R2: In the cycle after phase one ends, `selRef` goes high and the counter restarts from zero. If `cmpZero` rises during the k-th cycle of phase two (counting from 1) and stays high, the result is k+1. This includes the two synchronizer stages.
- R3: If the counter reaches 2^`CNT_W`-1 while the synchronized comparator is still low, the conversion ends with `result` equal to 2^`CNT_W`-1 and `overRange` equal to 1. If the trip is seen in that same cycle, the conversion ends normally with `overRange` equal to 0.
- R4: `donePulse` is high for exactly one cycle, and `result`/`overRange` are already valid in that cycle. `busy` is high in that cycle and low in the next.
- R5: `result` and `overRange` keep their values while idle. An accepted start clears both to 0.
- R6: `startReq` is ignored whenever `busy` is high (phase one, phase two and the done cycle). It neither restarts nor lengthens the conversion.
- R7: `selZero` is high exactly when the block is idle. At most one of `selZero`, `selInput`, `selRef` is high at any time. `busy` is high in every non-idle state.
- R8: After reset the block is idle: `selZero`=1, `busy`=0, `donePulse`=0, `result`=0, `overRange`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Conversion request, sampled while idle |
| cmpZero | input | 1 | Asynchronous comparator: high when integrator output is at or past zero |
| selInput | output | 1 | Connect unknown input to integrator (phase one) |
| selRef | output | 1 | Connect negative reference to integrator (phase two) |
| selZero | output | 1 | Hold integrator in auto-zero reset |
| busy | output | 1 | Conversion in progress |
| donePulse | output | 1 | One-cycle strobe when the result is latched |
| result | output | CNT_W | Phase-two count, held until the next start |
| overRange | output | 1 | Result saturated because the comparator never tripped |

## Verification
The assertions check on every cycle that the phase-one select stays high until the counter reaches its last tick, and that the counter never wraps past full scale. They also check that an overrange result is always full scale, that the done strobe lasts a single cycle, that the result register changes only on a start or a latch, and that the selects never overlap. The exact relation between the time the comparator trips and the latched count can only be shown by the bench's scenarios. The same holds for the saturation boundary at full scale and for start requests being ignored in each busy state. To show these, the bench sweeps every trip time from one cycle up to beyond full scale and compares each result with arithmetic computed from that trip time.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INT   = 2'd1,
    ST_DEINT = 2'd2,
    ST_DONE  = 2'd3
  } convState_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic clrRes;
    logic latchRes;
    logic setOvr;
  } dpStrobe_t;

endpackage

// File: rtl/dslope_dp.sv
module dslope_dp
  import dslope_pkg::*;
#(
  parameter int INT_TICKS = 16,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpAsync,
  input  dpStrobe_t        strobe,
  output logic             cmpSync,
  output logic             intLast,
  output logic             cntFull,
  output logic [CNT_W-1:0] result,
  output logic             overRange
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(INT_TICKS - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       cnt;

  // comparator synchronizer, one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[g] <= 1'b0;
      else if (g == 0) syncChain[g] <= cmpAsync;
      else syncChain[g] <= syncChain[(g == 0) ? 0 : g-1];
    end
  end
  assign cmpSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strobe.clrCnt) cnt <= '0;
    else if (strobe.incCnt && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign intLast = (cnt == INT_LAST);
  assign cntFull = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result    <= '0;
      overRange <= 1'b0;
    end else if (strobe.clrRes) begin
      result    <= '0;
      overRange <= 1'b0;
    end else if (strobe.latchRes) begin
      result    <= cnt;
      overRange <= strobe.setOvr;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX && !strobe.clrCnt) |=> cnt == CNT_MAX); // R3
  AST_OVR_SAT: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> result == CNT_MAX); // R3
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrRes && !strobe.latchRes) |=> ($stable(result) && $stable(overRange))); // R5

endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dslope_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      cmpSync,
  input  logic      intLast,
  input  logic      cntFull,
  output dpStrobe_t strobe,
  output logic      selInput,
  output logic      selRef,
  output logic      selZero,
  output logic      busy,
  output logic      donePulse
);

  convState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        strobe.clrCnt = 1'b1;
        strobe.clrRes = 1'b1;
        stateNxt      = ST_INT;
      end
      ST_INT: if (intLast) begin
        strobe.clrCnt = 1'b1;
        stateNxt      = ST_DEINT;
      end else begin
        strobe.incCnt = 1'b1;
      end
      ST_DEINT: if (cmpSync) begin
        strobe.latchRes = 1'b1;
        stateNxt        = ST_DONE;
      end else if (cntFull) begin
        strobe.latchRes = 1'b1;
        strobe.setOvr   = 1'b1;
        stateNxt        = ST_DONE;
      end else begin
        strobe.incCnt = 1'b1;
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign selZero   = (state == ST_IDLE);
  assign selInput  = (state == ST_INT);
  assign selRef    = (state == ST_DEINT);
  assign donePulse = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);

  AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (selInput && !intLast) |=> selInput); // R1
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> (!donePulse && !busy)); // R4
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selInput, selRef, selZero})); // R7
  AST_BUSY_NOSTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !selInput) |=> !selInput); // R6

endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
  import dslope_pkg::*;
#(
  parameter int INT_TICKS = 16,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             cmpZero,
  output logic             selInput,
  output logic             selRef,
  output logic             selZero,
  output logic             busy,
  output logic             donePulse,
  output logic [CNT_W-1:0] result,
  output logic             overRange
);

  dpStrobe_t strobe;
  logic      cmpSync, intLast, cntFull;

  initial begin
    if (INT_TICKS < SYNC_STAGES + 1 || INT_TICKS > (1 << CNT_W) - 1)
      $error("INT_TICKS out of range for CNT_W");
  end

  dslope_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .cmpSync   (cmpSync),
    .intLast   (intLast),
    .cntFull   (cntFull),
    .strobe    (strobe),
    .selInput  (selInput),
    .selRef    (selRef),
    .selZero   (selZero),
    .busy      (busy),
    .donePulse (donePulse)
  );

  dslope_dp #(
    .INT_TICKS (INT_TICKS),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmpAsync  (cmpZero),
    .strobe    (strobe),
    .cmpSync   (cmpSync),
    .intLast   (intLast),
    .cntFull   (cntFull),
    .result    (result),
    .overRange (overRange)
  );

endmodule

// File: tb/test_dual_slope_ctrl.sv
module test_dual_slope_ctrl;

  localparam int INT_TICKS = 16;
  localparam int CNT_W     = 8;
  localparam int FULL      = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startReq = 1'b0;
  logic             cmpZero = 1'b1;
  logic             selInput, selRef, selZero, busy, donePulse, overRange;
  logic [CNT_W-1:0] result;

  int testCnt = 0;
  int failCnt = 0;
  int thr = 0;
  int intCnt = 0;
  int refCnt = 0;

  always #2 clk = ~clk;

  dual_slope_ctrl #(.INT_TICKS(INT_TICKS), .CNT_W(CNT_W)) i_dual_slope_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpZero(cmpZero),
    .selInput(selInput), .selRef(selRef), .selZero(selZero), .busy(busy),
    .donePulse(donePulse), .result(result), .overRange(overRange)
  );

  // behavioural integrator and comparator
  always @(negedge clk) begin
    if (selInput) begin
      cmpZero = 1'b0;
      intCnt++;
      refCnt = 0;
    end
    if (selRef) begin
      refCnt++;
      if (refCnt == thr) cmpZero = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runConv(input int v, input bit poke);
    int expRes, expOvr, held;
    bit seen = 0;
    thr = v;
    @(negedge clk);
    intCnt = 0;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(result == 0 && !overRange, "R5 start clears result", int'(result), 0);
    check(selInput && !selZero && busy, "R7 selects in integrate", int'(selInput), 1);
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (poke) startReq = (intCnt == 3) || (refCnt == 10);
      if (donePulse) seen = 1;
    end
    check(seen, "R4 done seen", int'(seen), 1);
    expRes = (v + 1 > FULL) ? FULL : v + 1;
    expOvr = (v + 1 > FULL) ? 1 : 0;
    check(int'(result) == expRes, "R2 result", int'(result), expRes);
    check(int'(overRange) == expOvr, "R3 overrange", int'(overRange), expOvr);
    check(intCnt == INT_TICKS, "R1 integrate length", intCnt, INT_TICKS);
    check(busy, "R4 busy in done cycle", int'(busy), 1);
    startReq = poke;
    @(negedge clk);
    startReq = 1'b0;
    check(!donePulse && !busy && selZero, "R4 done one cycle", int'(donePulse), 0);
    if (poke) check(!selInput, "R6 start in done ignored", int'(selInput), 0);
    held = int'(result);
    repeat (3) @(negedge clk);
    check(int'(result) == held && int'(overRange) == expOvr && !busy,
          "R5 result held idle", int'(result), held);
  endtask

  initial begin
    #400000;
    failCnt++;
    testCnt++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(selZero && !busy && !donePulse && result == 0 && !overRange,
          "R8 reset state", int'(result), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(selZero && !selInput && !selRef && !busy, "R8 idle after reset", int'(busy), 0);
    for (int v = 1; v <= FULL + 2; v++) runConv(v, 1'b0);
    runConv(100, 1'b1);   // R6 starts during integrate, de-integrate and done
    runConv(FULL - 1, 1'b1);
    runConv(100000, 1'b0); // R3 comparator never trips
    runConv(1, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule